// File: doc/BRIEF.md
# Priority Crossbar Pin Assigner

This block sits between a set of on-chip digital peripherals and the general-purpose pads of a chip. Software enables peripherals through two enable registers. The block then packs the signals of every enabled peripheral, in a fixed priority order, onto the lowest free pins of a claimable window at the bottom of the pin range. Pins marked as skipped or analog are passed over. Any pin that no peripheral claims stays a plain GPIO and drives its latch bit.

Each pin drives either push-pull or open-drain, chosen per pin. The value of every pad can always be read back, whatever the assignment. Each peripheral signal also gets an input routed back from the pin it owns. A signal that found no pin reads a constant high.

The pin assignment is worked out from the enable, skip and analog bits and held in a register. A configuration change therefore shows up on the pads after the next clock edge. Output values, output enables and read-back data pass straight through, with no register in their path.

Top module: `pin_crossbar`

## Requirements
- R1: Only pins 0 to XBAR_PINS-1 (default 0 to 19) can be claimed by a peripheral. Pins at or above XBAR_PINS always behave as GPIO.
- R2: The 21 peripheral signals are indexed in priority order as follows: 0-1 UART (TX, RX), 2-5 SPI, 6-7 SMBus, 8-9 comparator 0, 10-11 comparator 1, 12 SYSCLK, 13-18 PCA channels 0-5, 19 timer 0, 20 timer 1. The k-th enabled signal, counted from index 0 upward, owns the k-th eligible pin, counted from pin 0 upward.
- R3: A pin whose bit in `pin_skip` is 1 is never claimed. The next signal moves on to the next eligible pin, and the skipped pin acts as GPIO.
- R4: The bits of `xbar_en_a` enable the peripherals as follows: bit0 UART, bit1 SPI, bit2 SMBus, bit3 comparator 0, bit4 comparator 1, bit5 SYSCLK. In `xbar_en_b`, bits[2:0] give the number of PCA channels (any value above 6 counts as 6), bit3 enables timer 0 and bit4 enables timer 1.
- R5: `pin_rd[p]` equals `pad_in[p]` for every non-analog pin, regardless of any assignment.
- R6: When `pin_od[p]` is 1 the pin drives only a 0: `pad_oe[p]` is 1 only when the value is 0. When `pin_od[p]` is 0, `pad_oe[p]` follows the requested drive.
- R7: An unclaimed, non-analog pin outputs `gpio_latch[p]` and requests drive, subject to R6.
- R8: When enabled signals outnumber eligible pins, the excess lowest-priority signals are left unassigned, and their `periph_in` bit reads 1.
- R9: A pin whose `pin_analog` bit is 1 is treated as skipped, never drives (`pad_oe` is 0), and reads 0 on `pin_rd`.
- R10: After reset, every pin behaves as GPIO. A change of enable, skip or analog bits changes the assignment at the next rising clock edge.
- R11: A claimed pin outputs `periph_out[i]` with `periph_oe[i]` as its drive request, subject to R6. `periph_in[i]` returns that pin's `pin_rd` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the assignment register |
| rst_n | input | 1 | Synchronous active-low reset |
| xbar_en_a | input | 6 | Peripheral enable bits, first register |
| xbar_en_b | input | 5 | PCA channel count and timer enables |
| pin_skip | input | XBAR_PINS | Per-pin skip mask for the claimable window |
| pin_analog | input | NUM_PINS | Per-pin analog mode |
| pin_od | input | NUM_PINS | Per-pin open-drain select (1) or push-pull (0) |
| gpio_latch | input | NUM_PINS | GPIO output latch values |
| pad_in | input | NUM_PINS | Sensed pad levels |
| pad_out | output | NUM_PINS | Pad drive value |
| pad_oe | output | NUM_PINS | Pad drive enable |
| pin_rd | output | NUM_PINS | Pin read-back value |
| periph_out | input | 21 | Peripheral output values, priority-indexed |
| periph_oe | input | 21 | Peripheral drive requests, priority-indexed |
| periph_in | output | 21 | Routed pin inputs to each peripheral signal |

## Verification
The hardest case to reach is overflow. Enough signals must be enabled to run past the window, while skip and analog pins are spread through it, so that the last few timer and PCA signals lose their pins. The stimulus enables all 21 signals and skips three pins, then drives every pad low. Under that stimulus, only an unassigned signal can show a 1 on `periph_in`. A separate scenario changes the enables between clock edges and samples the pads before and after the next edge, which exposes the one-cycle assignment latency.

// File: rtl/xbar_pkg.sv
// Shared constants and types for the pin crossbar.
// Assumes a fixed peripheral signal set; indices follow priority order.
package xbar_pkg;
    localparam int NUM_SIG   = 21;
    localparam int SIG_W     = $clog2(NUM_SIG);
    localparam int EN_A_W    = 6;
    localparam int EN_B_W    = 5;
    localparam int PCA_MAX   = 6;
    localparam int PCA_CNT_W = 3;

    // group base index and width, highest priority first
    localparam int SIG_UART = 0;   localparam int N_UART = 2;
    localparam int SIG_SPI  = 2;   localparam int N_SPI  = 4;
    localparam int SIG_SMB  = 6;   localparam int N_SMB  = 2;
    localparam int SIG_CMPA = 8;   localparam int N_CMPA = 2;
    localparam int SIG_CMPB = 10;  localparam int N_CMPB = 2;
    localparam int SIG_CLKO = 12;
    localparam int SIG_PCA  = 13;
    localparam int SIG_TMR0 = 19;
    localparam int SIG_TMR1 = 20;

    // enable bit positions
    localparam int ENA_UART = 0;
    localparam int ENA_SPI  = 1;
    localparam int ENA_SMB  = 2;
    localparam int ENA_CMPA = 3;
    localparam int ENA_CMPB = 4;
    localparam int ENA_CLKO = 5;
    localparam int ENB_TMR0 = 3;
    localparam int ENB_TMR1 = 4;

    typedef struct packed {
        logic             hit;
        logic [SIG_W-1:0] sel;
    } pin_map_t;
endpackage

// File: rtl/xbar_sig_active.sv
// Expands the two enable registers into one active bit per peripheral signal.
// Assumes the PCA count field saturates at PCA_MAX.
module xbar_sig_active
    import xbar_pkg::*;
(
    input  logic [EN_A_W-1:0]  en_a,
    input  logic [EN_B_W-1:0]  en_b,
    output logic [NUM_SIG-1:0] sig_act
);
    logic [PCA_CNT_W-1:0] pca_n;

    // decode group enables and saturated PCA channel count
    always_comb begin
        pca_n = (en_b[PCA_CNT_W-1:0] > PCA_CNT_W'(PCA_MAX)) ? PCA_CNT_W'(PCA_MAX)
                                                             : en_b[PCA_CNT_W-1:0];
        sig_act = '0;
        sig_act[SIG_UART +: N_UART] = {N_UART{en_a[ENA_UART]}};
        sig_act[SIG_SPI  +: N_SPI ] = {N_SPI{en_a[ENA_SPI]}};
        sig_act[SIG_SMB  +: N_SMB ] = {N_SMB{en_a[ENA_SMB]}};
        sig_act[SIG_CMPA +: N_CMPA] = {N_CMPA{en_a[ENA_CMPA]}};
        sig_act[SIG_CMPB +: N_CMPB] = {N_CMPB{en_a[ENA_CMPB]}};
        sig_act[SIG_CLKO]           = en_a[ENA_CLKO];
        for (int k = 0; k < PCA_MAX; k++)
            sig_act[SIG_PCA + k] = (PCA_CNT_W'(k) < pca_n);
        sig_act[SIG_TMR0] = en_b[ENB_TMR0];
        sig_act[SIG_TMR1] = en_b[ENB_TMR1];
    end
endmodule

// File: rtl/xbar_rank_map.sv
// Pairs active signals with eligible pins by rank: the k-th active signal
// goes to the k-th eligible pin. Purely combinational.
// Assumes sig_act is in priority order (index 0 highest).
module xbar_rank_map
    import xbar_pkg::*;
#(
    parameter int XBAR_PINS = 20
) (
    input  logic [NUM_SIG-1:0]             sig_act,
    input  logic [XBAR_PINS-1:0]           pin_elig,
    output pin_map_t [XBAR_PINS-1:0]       pin_map
);
    localparam int MAX_N  = (NUM_SIG > XBAR_PINS) ? NUM_SIG : XBAR_PINS;
    localparam int RANK_W = $clog2(MAX_N + 1);

    logic [RANK_W-1:0] sig_rank [NUM_SIG];
    logic [RANK_W-1:0] pin_rank [XBAR_PINS];
    logic [RANK_W-1:0] cnt_s;
    logic [RANK_W-1:0] cnt_p;

    // prefix ranks on both sides, then rank-equality match per pin
    always_comb begin
        cnt_s = '0;
        for (int i = 0; i < NUM_SIG; i++) begin
            sig_rank[i] = cnt_s;
            if (sig_act[i]) cnt_s = cnt_s + RANK_W'(1);
        end
        cnt_p = '0;
        for (int p = 0; p < XBAR_PINS; p++) begin
            pin_rank[p] = cnt_p;
            if (pin_elig[p]) cnt_p = cnt_p + RANK_W'(1);
        end
        for (int p = 0; p < XBAR_PINS; p++) begin
            pin_map[p] = '0;
            for (int i = 0; i < NUM_SIG; i++) begin
                if (sig_act[i] && pin_elig[p] && (sig_rank[i] == pin_rank[p])) begin
                    pin_map[p].hit = 1'b1;
                    pin_map[p].sel = SIG_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/xbar_pin_cell.sv
// Output stage of one pin: chooses GPIO or peripheral source and applies
// push-pull / open-drain and analog gating. Assumes open-drain never drives 1.
module xbar_pin_cell (
    input  logic analog,
    input  logic od,
    input  logic gpio_val,
    input  logic claimed,
    input  logic pv,
    input  logic poe,
    output logic pad_out,
    output logic pad_oe
);
    logic val;
    logic want;

    // select source, then gate drive by mode and analog setting
    always_comb begin
        val     = claimed ? pv  : gpio_val;
        want    = claimed ? poe : 1'b1;
        pad_out = val;
        pad_oe  = !analog && want && (!od || !val);
    end
endmodule

// File: rtl/pin_crossbar.sv
// Top of the priority crossbar. Registers the pin-to-signal map computed
// from enable, skip and analog bits; pad and peripheral data pass through
// combinationally using that map. Assumes pins >= XBAR_PINS are GPIO only.
module pin_crossbar
    import xbar_pkg::*;
#(
    parameter int NUM_PINS  = 29,
    parameter int XBAR_PINS = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EN_A_W-1:0]    xbar_en_a,
    input  logic [EN_B_W-1:0]    xbar_en_b,
    input  logic [XBAR_PINS-1:0] pin_skip,
    input  logic [NUM_PINS-1:0]  pin_analog,
    input  logic [NUM_PINS-1:0]  pin_od,
    input  logic [NUM_PINS-1:0]  gpio_latch,
    input  logic [NUM_PINS-1:0]  pad_in,
    output logic [NUM_PINS-1:0]  pad_out,
    output logic [NUM_PINS-1:0]  pad_oe,
    output logic [NUM_PINS-1:0]  pin_rd,
    input  logic [NUM_SIG-1:0]   periph_out,
    input  logic [NUM_SIG-1:0]   periph_oe,
    output logic [NUM_SIG-1:0]   periph_in
);
    logic [NUM_SIG-1:0]        sig_act;
    logic [XBAR_PINS-1:0]      pin_elig;
    pin_map_t [XBAR_PINS-1:0]  map_d;
    pin_map_t [XBAR_PINS-1:0]  map_q;

    assign pin_elig = ~pin_skip & ~pin_analog[XBAR_PINS-1:0];

    xbar_sig_active u_act (
        .en_a    (xbar_en_a),
        .en_b    (xbar_en_b),
        .sig_act (sig_act)
    );

    xbar_rank_map #(.XBAR_PINS(XBAR_PINS)) u_map (
        .sig_act  (sig_act),
        .pin_elig (pin_elig),
        .pin_map  (map_d)
    );

    // hold the assignment; reset leaves every pin unclaimed
    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end

    // read-back: pad level, forced low on analog pins
    assign pin_rd = pad_in & ~pin_analog;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic claimed;
        logic pv;
        logic poe;
        if (p < XBAR_PINS) begin : g_xbar
            assign claimed = map_q[p].hit;
            assign pv      = periph_out[map_q[p].sel];
            assign poe     = periph_oe[map_q[p].sel];
        end else begin : g_gpio
            assign claimed = 1'b0;
            assign pv      = 1'b0;
            assign poe     = 1'b0;
        end
        xbar_pin_cell u_cell (
            .analog   (pin_analog[p]),
            .od       (pin_od[p]),
            .gpio_val (gpio_latch[p]),
            .claimed  (claimed),
            .pv       (pv),
            .poe      (poe),
            .pad_out  (pad_out[p]),
            .pad_oe   (pad_oe[p])
        );
    end

    // route each signal's input from its owning pin, idle-high if none
    always_comb begin
        for (int i = 0; i < NUM_SIG; i++) begin
            periph_in[i] = 1'b1;
            for (int p = 0; p < XBAR_PINS; p++)
                if (map_q[p].hit && (map_q[p].sel == SIG_W'(i)))
                    periph_in[i] = pin_rd[p];
        end
    end
endmodule

// File: rtl/xbar_checker.sv
// Property checker for pin_crossbar, attached by bind below.
module xbar_checker
    import xbar_pkg::*;
#(
    parameter int NUM_PINS  = 29,
    parameter int XBAR_PINS = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [EN_A_W-1:0]        xbar_en_a,
    input  logic [EN_B_W-1:0]        xbar_en_b,
    input  logic [XBAR_PINS-1:0]     pin_skip,
    input  logic [NUM_PINS-1:0]      pin_analog,
    input  logic [NUM_PINS-1:0]      pin_od,
    input  logic [NUM_PINS-1:0]      gpio_latch,
    input  logic [NUM_PINS-1:0]      pad_out,
    input  logic [NUM_PINS-1:0]      pad_oe,
    input  logic [NUM_SIG-1:0]       periph_in,
    input  pin_map_t [XBAR_PINS-1:0] map_q
);
    logic [XBAR_PINS-1:0] owners [NUM_SIG];

    // which pins currently claim each signal
    always_comb begin
        for (int i = 0; i < NUM_SIG; i++)
            for (int p = 0; p < XBAR_PINS; p++)
                owners[i][p] = map_q[p].hit && (map_q[p].sel == SIG_W'(i));
    end

    for (genvar i = 0; i < NUM_SIG; i++) begin : g_sig
        // R2: a signal is placed on at most one pin
        a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(owners[i]) <= 1);
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        // R9: analog pins never drive
        a_r9_analog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            pin_analog[p] |-> !pad_oe[p]);
        // R6: open-drain pins never drive a 1
        a_r6_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_od[p] && pad_oe[p]) |-> !pad_out[p]);
        if (p >= XBAR_PINS) begin : g_hi
            // R1: pins above the window follow their GPIO latch
            a_r1_high_pin_gpio: assert property (@(posedge clk) disable iff (!rst_n)
                !pin_analog[p] |-> (pad_out[p] == gpio_latch[p]));
        end else begin : g_lo
            // R3: a pin skipped in the previous cycle is GPIO now
            a_r3_skipped_gpio: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(pin_skip[p]) && !pin_analog[p]) |-> (pad_out[p] == gpio_latch[p]));
        end
    end

    // R8: with nothing enabled, every routed input idles high
    a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xbar_en_a == '0 && xbar_en_b == '0) |-> (&periph_in));
endmodule

bind pin_crossbar xbar_checker #(.NUM_PINS(NUM_PINS), .XBAR_PINS(XBAR_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xbar_en_a  (xbar_en_a),
    .xbar_en_b  (xbar_en_b),
    .pin_skip   (pin_skip),
    .pin_analog (pin_analog),
    .pin_od     (pin_od),
    .gpio_latch (gpio_latch),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .periph_in  (periph_in),
    .map_q      (map_q)
);

// File: tb/pin_crossbar_tb.sv
module pin_crossbar_tb;
    import xbar_pkg::*;
    localparam int NP = 29;
    localparam int NX = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    en_a = '0;
    logic [4:0]    en_b = '0;
    logic [NX-1:0] skip = '0;
    logic [NP-1:0] analog = '0, od = '0, gpio = '0, pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, pin_rd;
    logic [20:0]   pout = '0, poe = '0;
    logic [20:0]   pin_s;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic [NP-1:0] e_out, e_oe, e_rd;
    logic [20:0]   e_in;
    int            e_sel [NP];

    always #2 clk = ~clk;

    pin_crossbar #(.NUM_PINS(NP), .XBAR_PINS(NX)) u_dut (
        .clk(clk), .rst_n(rst_n), .xbar_en_a(en_a), .xbar_en_b(en_b),
        .pin_skip(skip), .pin_analog(analog), .pin_od(od), .gpio_latch(gpio),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_rd(pin_rd),
        .periph_out(pout), .periph_oe(poe), .periph_in(pin_s)
    );

    // expected outputs from the requirements, by a pointer walk over pins
    task automatic model(input bit none);
        logic [20:0] act;
        int pc, nxt;
        logic val, want;
        act = '0;
        if (!none) begin
            if (en_a[0]) act[1:0]   = '1;
            if (en_a[1]) act[5:2]   = '1;
            if (en_a[2]) act[7:6]   = '1;
            if (en_a[3]) act[9:8]   = '1;
            if (en_a[4]) act[11:10] = '1;
            if (en_a[5]) act[12]    = 1'b1;
            pc = int'(en_b[2:0]);
            if (pc > 6) pc = 6;
            for (int k = 0; k < pc; k++) act[13 + k] = 1'b1;
            act[19] = en_b[3];
            act[20] = en_b[4];
        end
        for (int p = 0; p < NP; p++) e_sel[p] = -1;
        nxt = 0;
        for (int i = 0; i < 21; i++) begin
            if (act[i]) begin
                while (nxt < NX && (skip[nxt] || analog[nxt])) nxt++;
                if (nxt < NX) begin
                    e_sel[nxt] = i;
                    nxt++;
                end
            end
        end
        e_in = '1;
        for (int p = 0; p < NP; p++) begin
            if (e_sel[p] >= 0) begin
                val  = pout[e_sel[p]];
                want = poe[e_sel[p]];
                e_in[e_sel[p]] = pad_in[p] & ~analog[p];
            end else begin
                val  = gpio[p];
                want = 1'b1;
            end
            e_out[p] = val;
            e_oe[p]  = !analog[p] && want && (!od[p] || !val);
            e_rd[p]  = pad_in[p] & ~analog[p];
        end
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] actual, input logic [31:0] expected);
        n_chk++;
        if (actual !== expected) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, actual, expected);
        end
    endtask

    task automatic cmp_all(input string req);
        check(req, "pad_out",   32'(pad_out), 32'(e_out));
        check(req, "pad_oe",    32'(pad_oe),  32'(e_oe));
        check(req, "pin_rd",    32'(pin_rd),  32'(e_rd));
        check(req, "periph_in", 32'(pin_s),   32'(e_in));
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // R10: during reset every pin is GPIO even with peripherals enabled
    task automatic t_reset();
        en_a = 6'h3F; en_b = 5'h1E; gpio = 29'h0A5C3E1; od = 29'h0000F00;
        pout = 21'h1FFFFF; poe = 21'h1FFFFF; pad_in = 29'h1234567;
        step(); step();
        model(1'b1);
        cmp_all("R10 reset");
        rst_n = 1'b1;
    endtask

    // R2 R11 R7: UART alone lands on pins 0 and 1
    task automatic t_uart();
        en_a = 6'h01; en_b = '0; od = '0; gpio = 29'h15555554;
        pout = 21'h000001; poe = 21'h000001; pad_in = 29'h0000002;
        step(); model(1'b0);
        cmp_all("R2 R11 R7 uart");
        check("R11", "uart rx from pin1", 32'(pin_s[1]), 32'd1);
    endtask

    // R2 R4: sparse enables pack in priority order
    task automatic t_priority();
        en_a = 6'b101010; en_b = 5'b10011;
        pout = 21'h0A5F3C; poe = 21'h1F7FBF; pad_in = 29'h0F0F0F0;
        step(); model(1'b0);
        cmp_all("R2 R4 priority");
    endtask

    // R3: skipped pins are passed over and stay GPIO
    task automatic t_skip();
        en_a = 6'h3F; en_b = 5'b01010; skip = 20'h08421; gpio = 29'h1ABCDEF;
        pout = 21'h155AA3; poe = 21'h1FFFFF; pad_in = 29'h0CCCCCC;
        step(); model(1'b0);
        cmp_all("R3 skip");
        check("R3", "skipped pin5 gpio", 32'(pad_out[5]), 32'(gpio[5]));
    endtask

    // R4: a PCA count of 7 behaves like 6
    task automatic t_pca_clamp();
        logic [NP-1:0] o6;
        skip = '0; en_a = '0; en_b = 5'b00110; pout = 21'h07E000; poe = '1;
        step(); o6 = pad_out;
        en_b = 5'b00111;
        step(); model(1'b0);
        cmp_all("R4 pca clamp");
        check("R4", "count7 equals count6", 32'(pad_out), 32'(o6));
    endtask

    // R8: overflow leaves the lowest-priority signals idle-high
    task automatic t_overflow();
        en_a = 6'h3F; en_b = 5'b11110; skip = 20'h10101; pad_in = '0;
        pout = 21'h0; poe = 21'h1FFFFF; gpio = 29'h1FFFFFFF;
        step(); model(1'b0);
        cmp_all("R8 overflow");
        check("R8", "last four signals idle", 32'(pin_s[20:17]), 32'hF);
        check("R8", "first signal reads pad", 32'(pin_s[0]), 32'd0);
    endtask

    // R9 R5: analog pins skipped, quiet, read 0
    task automatic t_analog();
        skip = '0; en_a = 6'h07; en_b = '0; analog = 29'h1000005; pad_in = '1;
        pout = 21'h0000AA; poe = '1;
        step(); model(1'b0);
        cmp_all("R9 R5 analog");
        check("R9", "analog pin0 read", 32'(pin_rd[0]), 32'd0);
        check("R5", "pin3 read", 32'(pin_rd[3]), 32'd1);
        analog = '0;
    endtask

    // R6: open-drain releases on 1, push-pull drives both
    task automatic t_open_drain();
        en_a = 6'h03; en_b = '0; od = 29'h1FFFF0F;
        gpio = 29'h0F0F0F0; pout = 21'h000025; poe = '1; pad_in = 29'h0123456;
        step(); model(1'b0);
        cmp_all("R6 open drain");
        od = '0;
    endtask

    // R1: pins above the window never get a peripheral
    task automatic t_high_pins();
        en_a = 6'h3F; en_b = 5'b11110; skip = '0; gpio = 29'h15A00000;
        pout = 21'h0; poe = '1;
        step(); model(1'b0);
        cmp_all("R1 high pins");
        check("R1", "high pin values", 32'(pad_out[NP-1:NX]), 32'(gpio[NP-1:NX]));
        check("R1", "high pin drive", 32'(pad_oe[NP-1:NX]), 32'h1FF);
    endtask

    // R10: a new configuration takes effect only at the next edge
    task automatic t_latency();
        en_a = 6'h01; en_b = '0; gpio = 29'h0000000; pout = 21'h000003; poe = '1;
        step(); model(1'b0);
        en_a = 6'h00;
        #1;
        cmp_all("R10 before edge");
        step(); model(1'b0);
        cmp_all("R10 after edge");
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        t_reset();
        t_uart();
        t_priority();
        t_skip();
        t_pca_clamp();
        t_overflow();
        t_analog();
        t_open_drain();
        t_high_pins();
        t_latency();
        done = 1;
        report();
    end
endmodule